// File: doc/BRIEF.md
# SIMT Warp Issue Scheduler

This block is the issue stage of a small streaming core. It keeps the context of up to `NUM_WARPS` warps: a program counter, a 32-bit active-thread mask, a load-wait flag and a small stack of divergence records for each warp. Every warp is a group of 32 threads that share one instruction stream. In each cycle the block picks one ready warp in round-robin order, presents that warp's PC on a fetch port, and in the next cycle places the decoded instruction on a dispatch port. The instruction goes out with the warp's ID, its active-thread mask and the base address of its private register slice.

A warp that issues a load waits until a load response carrying its ID comes back. In the meantime the other warps keep issuing, and moving from one warp to another costs no bubble. A branch on which the active threads disagree is run in series. The taken threads go first. The not-taken threads follow once the PC reaches the reconvergence PC, and at the second arrival the full mask is restored. Each resident warp owns a fixed register slice, so only `RF_REGS / REGS_PER_WARP` warps can be resident. A heavier per-warp register budget therefore means fewer warps to switch between. Fetch, decode, execution and memory are stood in for by the fetch, instruction and load-response ports.

Top module: `simt_warp_sched`

## Requirements
- R1: After reset no warp is resident. `disp_valid_o` and `fetch_valid_o` are low, `launch_full_o` is low and `launch_wid_o` is 0.
- R2: At most `min(NUM_WARPS, RF_REGS/REGS_PER_WARP)` warps are resident. A launch takes the lowest free slot, which `launch_wid_o` shows. When every slot is taken, `launch_full_o` is high and a launch is ignored.
- R3: A warp picked on the fetch port in cycle t appears on the dispatch port in cycle t+1 with the same ID and PC, its active mask, the op and `disp_rf_base_o = wid * REGS_PER_WARP`.
- R4: Among ready warps the pick is round-robin, starting after the warp issued last. Different warps issue on back-to-back cycles with no idle cycle between them.
- R5: Issuing a load (op 1) makes the warp wait. A waiting warp is never picked until `ld_resp_i` arrives with its ID, and it then resumes at the instruction after the load.
- R6: In a cycle with no ready warp, nothing is fetched and `disp_valid_o` is low in the following cycle.
- R7: An ALU op (0) or a load op (1) advances the warp's PC by one and leaves the mask unchanged.
- R8: A branch (op 2) is uniform when, for every active thread i, bit i of `instr_cond_i` has the same value. If all are set, the PC becomes the target. If all are clear, the PC advances by one. In both cases the mask and the stack stay unchanged.
- R9: A divergent branch first runs the threads whose condition bit is set, at the target, with only those threads in the mask. When the PC reaches the reconvergence PC, the remaining threads run from the branch PC + 1. When the PC reaches the reconvergence PC again, the full mask is restored there. Nesting is supported up to `STACK_DEPTH` levels.
- R10: An exit (op 3) removes every active thread whose condition bit is set. A warp whose mask reaches zero with no open divergence is retired, and its slot can be launched again. No instruction is ever dispatched with an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Start a new warp with all 32 threads active |
| launch_pc_i | input | PC_W | Start PC of the new warp |
| launch_full_o | output | 1 | No free resident slot |
| launch_wid_o | output | log2(NUM_WARPS) | Slot the next launch will take |
| fetch_valid_o | output | 1 | A warp is picked this cycle |
| fetch_wid_o | output | log2(NUM_WARPS) | Picked warp |
| fetch_pc_o | output | PC_W | PC of the picked warp |
| instr_op_i | input | 2 | Op at fetch_pc_o: 0 ALU, 1 load, 2 branch, 3 exit |
| instr_cond_i | input | 32 | Per-thread condition, bit i for thread i |
| instr_target_i | input | PC_W | Branch target |
| instr_reconv_i | input | PC_W | Reconvergence PC of a branch |
| ld_resp_i | input | 1 | A load response returns |
| ld_resp_wid_i | input | log2(NUM_WARPS) | Warp the load response belongs to |
| disp_valid_o | output | 1 | Dispatch slot holds an instruction |
| disp_wid_o | output | log2(NUM_WARPS) | Issuing warp |
| disp_pc_o | output | PC_W | PC of the issued instruction |
| disp_mask_o | output | 32 | Active-thread mask |
| disp_op_o | output | 2 | Issued op |
| disp_rf_base_o | output | log2(RF_REGS) | Register slice base of the warp |

## Verification
On every cycle the assertions check four things: each dispatch matches the previous cycle's fetch pick, only ready warps are picked, a warp that has just issued a load is not picked again right away, and no dispatch carries an empty mask or an out-of-range warp ID. The order of the two divergent paths, the mask restored at reconvergence, round-robin fairness, resumption after a load response, and slot reuse after retirement only show up across a sequence of instructions. The bench scenarios check those against hand-computed instruction traces.

// File: rtl/simt_pkg.sv
package simt_pkg;
  localparam int WARP_SIZE = 32;

  typedef enum logic [1:0] {
    OP_ALU    = 2'd0,
    OP_LOAD   = 2'd1,
    OP_BRANCH = 2'd2,
    OP_EXIT   = 2'd3
  } op_e;

  typedef logic [WARP_SIZE-1:0] tmask_t;
endpackage

// File: rtl/simt_rr_pick.sv
module simt_rr_pick #(
  parameter  int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          gnt_valid_o,
  output logic [IW-1:0] gnt_idx_o
);
  // search starts one past the last grant
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int k = 1; k <= N; k++) begin
      logic [IW-1:0] idx;
      idx = IW'((int'(last_i) + k) % N);
      if (!gnt_valid_o && req_i[idx]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = idx;
      end
    end
  end
endmodule

// File: rtl/simt_warp_ctx.sv
module simt_warp_ctx
  import simt_pkg::*;
#(
  parameter  int PC_W  = 16,
  parameter  int DEPTH = 4,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_i,
  input  logic [PC_W-1:0] launch_pc_i,
  input  logic            issue_i,
  input  op_e             op_i,
  input  tmask_t          cond_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [PC_W-1:0] reconv_i,
  input  logic            ld_done_i,
  output logic            valid_o,
  output logic            ready_o,
  output logic [PC_W-1:0] pc_o,
  output tmask_t          mask_o
);
  logic            valid_q, valid_d, wait_q, wait_d;
  logic [PC_W-1:0] pc_q, pc_d;
  tmask_t          mask_q, mask_d;
  logic [SP_W-1:0] sp_q, sp_d;
  logic [PC_W-1:0] rc_q[DEPTH], rc_d[DEPTH];
  logic [PC_W-1:0] ntpc_q[DEPTH], ntpc_d[DEPTH];
  tmask_t          ntm_q[DEPTH], ntm_d[DEPTH];
  tmask_t          full_q[DEPTH], full_d[DEPTH];
  logic [DEPTH-1:0] ph_q, ph_d;  // 1: not-taken path running

  always_comb begin
    tmask_t          hit;
    logic [IX_W-1:0] wr_ix;
    logic [IX_W-1:0] top;
    valid_d = valid_q;
    wait_d  = wait_q;
    pc_d    = pc_q;
    mask_d  = mask_q;
    sp_d    = sp_q;
    rc_d    = rc_q;
    ntpc_d  = ntpc_q;
    ntm_d   = ntm_q;
    full_d  = full_q;
    ph_d    = ph_q;
    hit     = mask_q & cond_i;
    wr_ix   = sp_q[IX_W-1:0];
    top     = '0;

    if (ld_done_i) wait_d = 1'b0;

    if (issue_i) begin
      pc_d = pc_q + 1'b1;
      case (op_i)
        OP_LOAD: wait_d = 1'b1;
        OP_BRANCH: begin
          if (hit == mask_q) begin
            pc_d = target_i;
          end else if (hit != '0 && 32'(sp_q) < DEPTH) begin
            rc_d[wr_ix]   = reconv_i;
            ntpc_d[wr_ix] = pc_q + 1'b1;
            ntm_d[wr_ix]  = mask_q & ~cond_i;
            full_d[wr_ix] = mask_q;
            ph_d[wr_ix]   = 1'b0;
            sp_d          = sp_q + 1'b1;
            mask_d        = hit;
            pc_d          = target_i;
          end
        end
        OP_EXIT: begin
          mask_d = mask_q & ~cond_i;
          for (int i = 0; i < DEPTH; i++) begin
            ntm_d[i]  = ntm_q[i] & ~hit;
            full_d[i] = full_q[i] & ~hit;
          end
        end
        default: ;
      endcase

      // reconvergence: switch to the pending path or pop
      if (sp_d != '0) begin
        top = IX_W'(sp_d - 1'b1);
        if (pc_d == rc_d[top] || mask_d == '0) begin
          if (!ph_d[top] && ntpc_d[top] != rc_d[top]) begin
            ph_d[top] = 1'b1;
            mask_d    = ntm_d[top];
            pc_d      = ntpc_d[top];
          end else begin
            mask_d = full_d[top];
            pc_d   = rc_d[top];
            sp_d   = sp_d - 1'b1;
          end
        end
      end

      if (op_i == OP_EXIT && mask_d == '0 && sp_d == '0) valid_d = 1'b0;
    end

    if (launch_i) begin
      valid_d = 1'b1;
      wait_d  = 1'b0;
      pc_d    = launch_pc_i;
      mask_d  = '1;
      sp_d    = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wait_q  <= 1'b0;
      pc_q    <= '0;
      mask_q  <= '0;
      sp_q    <= '0;
      ph_q    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        rc_q[i]   <= '0;
        ntpc_q[i] <= '0;
        ntm_q[i]  <= '0;
        full_q[i] <= '0;
      end
    end else begin
      valid_q <= valid_d;
      wait_q  <= wait_d;
      pc_q    <= pc_d;
      mask_q  <= mask_d;
      sp_q    <= sp_d;
      ph_q    <= ph_d;
      rc_q    <= rc_d;
      ntpc_q  <= ntpc_d;
      ntm_q   <= ntm_d;
      full_q  <= full_d;
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q & ~wait_q;
  assign pc_o    = pc_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/simt_warp_sched.sv
module simt_warp_sched
  import simt_pkg::*;
#(
  parameter  int NUM_WARPS     = 8,
  parameter  int PC_W          = 16,
  parameter  int STACK_DEPTH   = 4,
  parameter  int RF_REGS       = 512,
  parameter  int REGS_PER_WARP = 64,
  localparam int WID_W         = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int BASE_W        = (RF_REGS > 1) ? $clog2(RF_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [PC_W-1:0]   launch_pc_i,
  output logic              launch_full_o,
  output logic [WID_W-1:0]  launch_wid_o,
  output logic              fetch_valid_o,
  output logic [WID_W-1:0]  fetch_wid_o,
  output logic [PC_W-1:0]   fetch_pc_o,
  input  logic [1:0]        instr_op_i,
  input  logic [31:0]       instr_cond_i,
  input  logic [PC_W-1:0]   instr_target_i,
  input  logic [PC_W-1:0]   instr_reconv_i,
  input  logic              ld_resp_i,
  input  logic [WID_W-1:0]  ld_resp_wid_i,
  output logic              disp_valid_o,
  output logic [WID_W-1:0]  disp_wid_o,
  output logic [PC_W-1:0]   disp_pc_o,
  output logic [31:0]       disp_mask_o,
  output logic [1:0]        disp_op_o,
  output logic [BASE_W-1:0] disp_rf_base_o
);
  localparam int RES_RAW = RF_REGS / REGS_PER_WARP;
  localparam int MAX_RES = (RES_RAW < NUM_WARPS) ? RES_RAW : NUM_WARPS;

  logic [NUM_WARPS-1:0] valid_w, ready_w;
  logic [NUM_WARPS-1:0] launch_sel, issue_sel, ld_sel;
  logic [PC_W-1:0]      pc_w[NUM_WARPS];
  tmask_t               mask_w[NUM_WARPS];
  op_e                  op;

  logic             free_found;
  logic [WID_W-1:0] free_idx;
  logic             pick_v;
  logic [WID_W-1:0] pick_w, last_q;

  assign op = op_e'(instr_op_i);

  // lowest free resident slot
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int w = 0; w < MAX_RES; w++) begin
      if (!valid_w[w] && !free_found) begin
        free_found = 1'b1;
        free_idx   = WID_W'(w);
      end
    end
  end

  assign launch_full_o = ~free_found;
  assign launch_wid_o  = free_idx;

  simt_rr_pick #(.N(NUM_WARPS)) i_pick (
    .req_i      (ready_w),
    .last_i     (last_q),
    .gnt_valid_o(pick_v),
    .gnt_idx_o  (pick_w)
  );

  assign fetch_valid_o = pick_v;
  assign fetch_wid_o   = pick_w;
  assign fetch_pc_o    = pc_w[pick_w];

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
    assign launch_sel[g] = launch_i & free_found & (free_idx == WID_W'(g));
    assign issue_sel[g]  = pick_v & (pick_w == WID_W'(g));
    assign ld_sel[g]     = ld_resp_i & (ld_resp_wid_i == WID_W'(g));
    if (g < MAX_RES) begin : g_res
      simt_warp_ctx #(.PC_W(PC_W), .DEPTH(STACK_DEPTH)) i_ctx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .launch_i   (launch_sel[g]),
        .launch_pc_i(launch_pc_i),
        .issue_i    (issue_sel[g]),
        .op_i       (op),
        .cond_i     (instr_cond_i),
        .target_i   (instr_target_i),
        .reconv_i   (instr_reconv_i),
        .ld_done_i  (ld_sel[g]),
        .valid_o    (valid_w[g]),
        .ready_o    (ready_w[g]),
        .pc_o       (pc_w[g]),
        .mask_o     (mask_w[g])
      );
    end else begin : g_nores
      // no register slice left for this slot
      assign valid_w[g] = 1'b0;
      assign ready_w[g] = 1'b0;
      assign pc_w[g]    = '0;
      assign mask_w[g]  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q         <= WID_W'(NUM_WARPS - 1);
      disp_valid_o   <= 1'b0;
      disp_wid_o     <= '0;
      disp_pc_o      <= '0;
      disp_mask_o    <= '0;
      disp_op_o      <= '0;
      disp_rf_base_o <= '0;
    end else begin
      disp_valid_o <= pick_v;
      if (pick_v) begin
        last_q         <= pick_w;
        disp_wid_o     <= pick_w;
        disp_pc_o      <= pc_w[pick_w];
        disp_mask_o    <= mask_w[pick_w];
        disp_op_o      <= instr_op_i;
        disp_rf_base_o <= BASE_W'(int'(pick_w) * REGS_PER_WARP);
      end
    end
  end
endmodule

// File: rtl/simt_warp_sched_chk.sv
module simt_warp_sched_chk #(
  parameter  int NUM_WARPS     = 8,
  parameter  int PC_W          = 16,
  parameter  int RF_REGS       = 512,
  parameter  int REGS_PER_WARP = 64,
  localparam int WID_W         = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fetch_valid_o,
  input logic [WID_W-1:0]     fetch_wid_o,
  input logic [PC_W-1:0]      fetch_pc_o,
  input logic                 disp_valid_o,
  input logic [WID_W-1:0]     disp_wid_o,
  input logic [PC_W-1:0]      disp_pc_o,
  input logic [31:0]          disp_mask_o,
  input logic [1:0]           disp_op_o,
  input logic [NUM_WARPS-1:0] ready_w
);
  localparam int RES_RAW = RF_REGS / REGS_PER_WARP;
  localparam int MAX_RES = (RES_RAW < NUM_WARPS) ? RES_RAW : NUM_WARPS;

  AST_FETCH_TO_DISP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |=> disp_valid_o && disp_wid_o == $past(fetch_wid_o)
                      && disp_pc_o == $past(fetch_pc_o)); // R3
  AST_IDLE_NO_DISP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_o |=> !disp_valid_o); // R6
  AST_PICK_IS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> ready_w[fetch_wid_o]); // R5
  AST_LOAD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && disp_op_o == 2'd1) |-> !(fetch_valid_o && fetch_wid_o == disp_wid_o)); // R5
  AST_MASK_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> disp_mask_o != '0); // R10
  AST_WID_RESIDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> 32'(disp_wid_o) < MAX_RES); // R2
endmodule

bind simt_warp_sched simt_warp_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .PC_W(PC_W), .RF_REGS(RF_REGS), .REGS_PER_WARP(REGS_PER_WARP)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .fetch_valid_o(fetch_valid_o), .fetch_wid_o(fetch_wid_o), .fetch_pc_o(fetch_pc_o),
  .disp_valid_o(disp_valid_o), .disp_wid_o(disp_wid_o), .disp_pc_o(disp_pc_o),
  .disp_mask_o(disp_mask_o), .disp_op_o(disp_op_o), .ready_w(ready_w)
);

// File: tb/test_simt_warp_sched.sv
module test_simt_warp_sched;
  localparam int NW = 8, PCW = 8, SD = 2, RFR = 320, RPW = 64;
  localparam int WW = 3, BW = $clog2(RFR);
  localparam logic [31:0] FULL = 32'hFFFF_FFFF, LO = 32'h0000_FFFF, HI = 32'hFFFF_0000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic launch_i = 1'b0, ld_resp_i = 1'b0;
  logic [PCW-1:0] launch_pc_i = '0;
  logic [WW-1:0] ld_resp_wid_i = '0;
  logic launch_full_o, fetch_valid_o, disp_valid_o;
  logic [WW-1:0] launch_wid_o, fetch_wid_o, disp_wid_o;
  logic [PCW-1:0] fetch_pc_o, disp_pc_o, instr_target_i, instr_reconv_i;
  logic [1:0] instr_op_i, disp_op_o;
  logic [31:0] instr_cond_i, disp_mask_o;
  logic [BW-1:0] disp_rf_base_o;

  logic [1:0] p_op[256];
  logic [31:0] p_cond[256];
  logic [PCW-1:0] p_tgt[256], p_rc[256];

  assign instr_op_i     = p_op[fetch_pc_o];
  assign instr_cond_i   = p_cond[fetch_pc_o];
  assign instr_target_i = p_tgt[fetch_pc_o];
  assign instr_reconv_i = p_rc[fetch_pc_o];

  simt_warp_sched #(.NUM_WARPS(NW), .PC_W(PCW), .STACK_DEPTH(SD), .RF_REGS(RFR),
                    .REGS_PER_WARP(RPW)) i_simt_warp_sched (
    .clk_i(clk), .rst_ni(rst_ni), .launch_i(launch_i), .launch_pc_i(launch_pc_i),
    .launch_full_o(launch_full_o), .launch_wid_o(launch_wid_o),
    .fetch_valid_o(fetch_valid_o), .fetch_wid_o(fetch_wid_o), .fetch_pc_o(fetch_pc_o),
    .instr_op_i(instr_op_i), .instr_cond_i(instr_cond_i), .instr_target_i(instr_target_i),
    .instr_reconv_i(instr_reconv_i), .ld_resp_i(ld_resp_i), .ld_resp_wid_i(ld_resp_wid_i),
    .disp_valid_o(disp_valid_o), .disp_wid_o(disp_wid_o), .disp_pc_o(disp_pc_o),
    .disp_mask_o(disp_mask_o), .disp_op_o(disp_op_o), .disp_rf_base_o(disp_rf_base_o));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // dispatch trace, sampled between edges
  int tr_n = 0;
  int tr_wid[1024], tr_pc[1024], tr_op[1024], tr_base[1024], tr_cyc[1024];
  logic [31:0] tr_mask[1024];
  always begin
    @(posedge clk);
    #2;
    if (rst_ni && disp_valid_o && tr_n < 1024) begin
      tr_wid[tr_n] = int'(disp_wid_o);
      tr_pc[tr_n] = int'(disp_pc_o);
      tr_op[tr_n] = int'(disp_op_o);
      tr_base[tr_n] = int'(disp_rf_base_o);
      tr_mask[tr_n] = disp_mask_o;
      tr_cyc[tr_n] = cyc;
      tr_n = tr_n + 1;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) begin
      p_op[i] = 2'd0; p_cond[i] = '0; p_tgt[i] = '0; p_rc[i] = '0;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; launch_i = 1'b0; ld_resp_i = 1'b0;
    tick(3);
    rst_ni = 1'b1;
    tick(1);
  endtask

  task automatic launch(input int pc, input int exp_wid);
    launch_i = 1'b1; launch_pc_i = PCW'(pc);
    chk("R2", "launch slot", launch_wid_o, exp_wid);
    tick(1);
    launch_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    int s;
    clear_prog();
    // R1 reset state
    do_reset();
    chk("R1", "disp_valid", disp_valid_o, 0);
    chk("R1", "fetch_valid", fetch_valid_o, 0);
    chk("R1", "launch_full", launch_full_o, 0);
    chk("R1", "launch_wid", launch_wid_o, 0);
    tick(3);
    chk("R6", "idle no dispatch", tr_n, 0);

    // round robin, zero-cost switching, rf base, pc advance
    s = tr_n;
    launch(10, 0); launch(20, 1); launch(30, 2);
    tick(12);
    for (int i = 0; i < 9; i++) begin
      chk("R4", "rr wid", tr_wid[s+i], i % 3);
      chk("R7", "pc advance", tr_pc[s+i], 10 * (i % 3 + 1) + i / 3);
      chk("R3", "rf base", tr_base[s+i], (i % 3) * RPW);
      chk("R3", "full mask", tr_mask[s+i], FULL);
      if (i > 0) chk("R4", "no bubble", tr_cyc[s+i] - tr_cyc[s+i-1], 1);
    end

    // load wait and skip
    do_reset();
    clear_prog();
    p_op[0] = 2'd1;
    s = tr_n;
    launch(0, 0); launch(0, 1);
    tick(5);
    chk("R5", "two loads only", tr_n - s, 2);
    chk("R5", "load op w0", tr_op[s], 1);
    chk("R5", "load w1", tr_wid[s+1], 1);
    chk("R6", "idle disp_valid", disp_valid_o, 0);
    chk("R6", "idle fetch_valid", fetch_valid_o, 0);
    ld_resp_i = 1'b1; ld_resp_wid_i = 3'd1;
    tick(1);
    ld_resp_i = 1'b0;
    tick(5);
    ld_resp_i = 1'b1; ld_resp_wid_i = 3'd0;
    tick(1);
    ld_resp_i = 1'b0;
    tick(4);
    begin
      int k, run;
      k = s + 2; run = 0;
      while (k < tr_n && tr_wid[k] == 1) begin
        chk("R5", "w1 resumes seq", tr_pc[k], 1 + run);
        k++; run++;
      end
      chk("R5", "w1 alone while w0 waits", run >= 5, 1);
      chk("R5", "w0 resumes after load", tr_pc[k], 1);
      chk("R4", "rr after resume", tr_wid[k+1], 1);
    end

    // divergence, uniform branches, exit
    do_reset();
    clear_prog();
    p_op[0] = 2'd2; p_cond[0] = LO; p_tgt[0] = 8'd4; p_rc[0] = 8'd7;
    p_op[3] = 2'd2; p_cond[3] = FULL; p_tgt[3] = 8'd7;
    p_op[7] = 2'd2; p_cond[7] = '0; p_tgt[7] = 8'd20;
    p_op[8] = 2'd3; p_cond[8] = FULL;
    s = tr_n;
    launch(0, 0);
    tick(14);
    begin
      int e_pc[9] = '{0, 4, 5, 6, 1, 2, 3, 7, 8};
      logic [31:0] e_m[9] = '{FULL, LO, LO, LO, HI, HI, HI, FULL, FULL};
      chk("R10", "retired after exit", tr_n - s, 9);
      for (int i = 0; i < 9; i++) begin
        chk((i == 4 || i == 7) ? "R9" : "R8", "div pc", tr_pc[s+i], e_pc[i]);
        chk("R9", "div mask", tr_mask[s+i], e_m[i]);
      end
    end
    chk("R10", "slot free after retire", launch_full_o, 0);

    // residency limit, ignored launch, partial exit and slot reuse
    do_reset();
    clear_prog();
    p_op[0] = 2'd1;
    p_op[1] = 2'd3; p_cond[1] = LO;
    p_op[2] = 2'd3; p_cond[2] = FULL;
    s = tr_n;
    for (int w = 0; w < 5; w++) launch(0, w);
    chk("R2", "full at limit", launch_full_o, 1);
    launch_i = 1'b1;
    tick(1);
    launch_i = 1'b0;
    tick(4);
    chk("R2", "extra launch ignored", tr_n - s, 5);
    for (int w = 0; w < 5; w++) begin
      chk("R5", "load order", tr_wid[s+w], w);
      chk("R3", "rf base slice", tr_base[s+w], w * RPW);
    end
    s = tr_n;
    ld_resp_i = 1'b1; ld_resp_wid_i = 3'd3;
    tick(1);
    ld_resp_i = 1'b0;
    tick(5);
    chk("R10", "exit trace len", tr_n - s, 2);
    chk("R10", "first exit mask", tr_mask[s], FULL);
    chk("R10", "partial exit mask", tr_mask[s+1], HI);
    chk("R10", "second exit pc", tr_pc[s+1], 2);
    chk("R10", "slot freed", launch_full_o, 0);
    chk("R2", "freed slot reused", launch_wid_o, 3);

    done = 1;
    report();
  end
endmodule